// File: doc/BRIEF.md
# Branch and Stack Sequencer

This block holds the program counter and stack pointer of a small 8-bit processor with 16-bit addresses. A decoder upstream gives it one branch-class request at a time: relative jump, conditional relative jump, loop-decrement-and-branch, absolute jump, conditional absolute jump, call, conditional call, return, conditional return, push and pop. Each request comes with an immediate byte or word, a register pair for push, the current loop counter and the flag byte. The block works out whether the branch is taken and computes the next PC and SP.

Stack traffic moves one byte per cycle through a simple memory port. A call or push writes two bytes downwards from the stack pointer. A return or pop reads two bytes upwards. A busy flag covers the access cycles, and a one-cycle done pulse marks the cycle in which the new PC and SP are visible.

Top module: `pcsp_sequencer`

## Requirements
- R1: After synchronous reset, pc is 0x0000, sp is 0x0000, and busy, done, mem_we, mem_re, b_we and pop_we are all low.
- R2: Op 0 (relative jump) sets pc to pc + 2 + the sign-extended byte req_imm[7:0]. sp is unchanged and done is high in the cycle after acceptance.
- R3: Op 1 (conditional relative jump) uses only req_cond[1:0]: 0 = Z clear, 1 = Z set, 2 = C clear, 3 = C set. Z is flags bit 6 and C is flags bit 0. req_cond[2] and the other flag bits have no effect. When the branch is not taken, pc advances by 2.
- R4: Op 2 (loop) drives b_out = b_in - 1 with a one-cycle b_we pulse together with done. It takes the relative branch only when that new value is nonzero; otherwise pc advances by 2.
- R5: Op 3 sets pc to req_imm. Op 4 does the same when the 3-bit condition holds: 0 Z clear, 1 Z set, 2 C clear, 3 C set, 4 P/V clear, 5 P/V set, 6 S clear, 7 S set. P/V is flags bit 2 and S is flags bit 7. When not taken, pc advances by 3.
- R6: Op 5 (call), or op 6 when its 3-bit condition holds, writes the high byte of pc + 3 at sp - 1 in the first access cycle and the low byte at sp - 2 in the second. It then sets pc to req_imm and sp to sp - 2.
- R7: Op 6 or op 8 with a false condition performs no memory access and leaves sp unchanged. pc advances by 3 (op 6) or by 1 (op 8), and done is high in the cycle after acceptance.
- R8: Op 7 (return), or op 8 when its 3-bit condition holds, reads the low byte at sp and then the high byte at sp + 1. It then loads pc with that word and sets sp to sp + 2.
- R9: Op 9 (push) writes the high byte of req_pair at sp - 1, then the low byte at sp - 2. It then sets sp to sp - 2 and pc to pc + 1.
- R10: Op 10 (pop) reads like R8. It then drives pop_data with the word and a one-cycle pop_we pulse together with done, sets sp to sp + 2 and pc to pc + 1.
- R11: Stack operations keep busy high for exactly the two access cycles, and done follows in the next cycle. A request presented while busy is ignored. Op codes 11 to 15 change nothing and raise no done.
- R12: sp arithmetic wraps modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when not busy |
| req_op | input | 4 | Operation code (0 to 10) |
| req_cond | input | 3 | Condition selector |
| req_imm | input | 16 | Displacement in bits 7:0, or absolute target |
| req_pair | input | 16 | Register pair to push |
| flags | input | 8 | Flag byte: S bit 7, Z bit 6, P/V bit 2, C bit 0 |
| b_in | input | 8 | Current loop counter |
| mem_rdata | input | 8 | Stack read data, valid in the cycle mem_re is high |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Stack access in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_we | output | 1 | Stack byte write strobe |
| mem_re | output | 1 | Stack byte read strobe |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Stack write byte |
| b_out | output | 8 | Decremented loop counter |
| b_we | output | 1 | Loop counter write strobe |
| pop_data | output | 16 | Popped register pair |
| pop_we | output | 1 | Pop write strobe |

## Verification
Every branch that touches no stack memory, whether taken or not, shows its new pc, b_out and done one cycle after the accepting edge. Calls, returns, pushes and pops spend two cycles on the memory port with busy high, and their pc, sp, pop_data and done appear one cycle after that. The bench drives each request, counts the cycles until done while sampling on falling edges, and checks that count against 1 or 3 before comparing results. Memory addresses and bytes are logged at each rising edge and compared in order once done is seen.

// File: rtl/pcsp_pkg.sv
package pcsp_pkg;

    typedef enum logic [3:0] {
        OP_JR      = 4'd0,
        OP_JR_IF   = 4'd1,
        OP_LOOP    = 4'd2,
        OP_JP      = 4'd3,
        OP_JP_IF   = 4'd4,
        OP_CALL    = 4'd5,
        OP_CALL_IF = 4'd6,
        OP_RET     = 4'd7,
        OP_RET_IF  = 4'd8,
        OP_PUSH    = 4'd9,
        OP_POP     = 4'd10
    } br_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_HI,
        ST_WR_LO,
        ST_RD_LO,
        ST_RD_HI
    } seq_st_e;

    // flag bits the condition logic looks at
    typedef struct packed {
        logic sign;
        logic zero;
        logic parity;
        logic carry;
    } flag_view_t;

    localparam int FLAG_C  = 0;
    localparam int FLAG_PV = 2;
    localparam int FLAG_Z  = 6;
    localparam int FLAG_S  = 7;

endpackage

// File: rtl/pcsp_cond_eval.sv
module pcsp_cond_eval
    import pcsp_pkg::*;
(
    input  logic [2:0]  cond,
    input  logic        short_form,
    input  flag_view_t  fv,
    output logic        taken
);
    logic [2:0] sel;
    logic       fbit;

    // relative forms only see the low two selector bits
    assign sel = short_form ? {1'b0, cond[1:0]} : cond;

    always_comb begin
        case (sel[2:1])
            2'd0:    fbit = fv.zero;
            2'd1:    fbit = fv.carry;
            2'd2:    fbit = fv.parity;
            default: fbit = fv.sign;
        endcase
    end

    // even selector: flag clear; odd selector: flag set
    assign taken = ~(fbit ^ sel[0]);

    always_comb begin
        if (short_form)
            a_r3_short_sel: assert (sel[2] == 1'b0);
    end

endmodule

// File: rtl/pcsp_rel_adder.sv
module pcsp_rel_adder #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] target
);
    localparam int EXT = AW - DW;

    logic [AW-1:0] disp_ext;

    assign disp_ext = {{EXT{disp[DW-1]}}, disp};
    // offset is counted from the end of the two-byte instruction
    assign target   = base + AW'(2) + disp_ext;

endmodule

// File: rtl/pcsp_sequencer.sv
module pcsp_sequencer
    import pcsp_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter logic [15:0] PC_RESET = 16'h0000,
    parameter logic [15:0] SP_RESET = 16'h0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [3:0]    req_op,
    input  logic [2:0]    req_cond,
    input  logic [AW-1:0] req_imm,
    input  logic [AW-1:0] req_pair,
    input  logic [7:0]    flags,
    input  logic [DW-1:0] b_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp,
    output logic          busy,
    output logic          done,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] b_out,
    output logic          b_we,
    output logic [AW-1:0] pop_data,
    output logic          pop_we
);
    localparam logic [AW-1:0] ONE  = AW'(1);
    localparam logic [AW-1:0] TWO  = AW'(2);
    localparam logic [AW-1:0] THREE = AW'(3);

    seq_st_e       st_q;
    br_op_e        op_q;
    br_op_e        op_in;
    logic [AW-1:0] pc_q, sp_q, data_q, tgt_q;
    logic [DW-1:0] lo_q;
    logic          done_q, b_we_q, pop_we_q;
    logic [DW-1:0] b_q;
    logic [AW-1:0] pop_q;

    flag_view_t    fv;
    logic          cond_ok;
    logic [AW-1:0] rel_tgt;
    logic [DW-1:0] b_dec;
    logic          unused_flags;

    assign op_in        = br_op_e'(req_op);
    assign fv           = '{sign: flags[FLAG_S], zero: flags[FLAG_Z],
                            parity: flags[FLAG_PV], carry: flags[FLAG_C]};
    assign unused_flags = ^{flags[5:3], flags[1]};
    assign b_dec        = b_in - DW'(1);

    pcsp_cond_eval u_cond (
        .cond       (req_cond),
        .short_form (op_in == OP_JR_IF),
        .fv         (fv),
        .taken      (cond_ok)
    );

    pcsp_rel_adder #(.AW(AW), .DW(DW)) u_rel (
        .base   (pc_q),
        .disp   (req_imm[DW-1:0]),
        .target (rel_tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            op_q     <= OP_JR;
            pc_q     <= AW'(PC_RESET);
            sp_q     <= AW'(SP_RESET);
            data_q   <= '0;
            tgt_q    <= '0;
            lo_q     <= '0;
            done_q   <= 1'b0;
            b_we_q   <= 1'b0;
            pop_we_q <= 1'b0;
            b_q      <= '0;
            pop_q    <= '0;
        end else begin
            done_q   <= 1'b0;
            b_we_q   <= 1'b0;
            pop_we_q <= 1'b0;
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    case (op_in)
                        OP_JR: begin
                            pc_q   <= rel_tgt;
                            done_q <= 1'b1;
                        end
                        OP_JR_IF: begin
                            pc_q   <= cond_ok ? rel_tgt : pc_q + TWO;
                            done_q <= 1'b1;
                        end
                        OP_LOOP: begin
                            pc_q   <= (b_dec != '0) ? rel_tgt : pc_q + TWO;
                            b_q    <= b_dec;
                            b_we_q <= 1'b1;
                            done_q <= 1'b1;
                        end
                        OP_JP: begin
                            pc_q   <= req_imm;
                            done_q <= 1'b1;
                        end
                        OP_JP_IF: begin
                            pc_q   <= cond_ok ? req_imm : pc_q + THREE;
                            done_q <= 1'b1;
                        end
                        OP_CALL, OP_CALL_IF: begin
                            if (op_in == OP_CALL || cond_ok) begin
                                data_q <= pc_q + THREE;
                                tgt_q  <= req_imm;
                                op_q   <= OP_CALL;
                                st_q   <= ST_WR_HI;
                            end else begin
                                pc_q   <= pc_q + THREE;
                                done_q <= 1'b1;
                            end
                        end
                        OP_PUSH: begin
                            data_q <= req_pair;
                            op_q   <= OP_PUSH;
                            st_q   <= ST_WR_HI;
                        end
                        OP_RET, OP_RET_IF: begin
                            if (op_in == OP_RET || cond_ok) begin
                                op_q <= OP_RET;
                                st_q <= ST_RD_LO;
                            end else begin
                                pc_q   <= pc_q + ONE;
                                done_q <= 1'b1;
                            end
                        end
                        OP_POP: begin
                            op_q <= OP_POP;
                            st_q <= ST_RD_LO;
                        end
                        default: ;
                    endcase
                end
                ST_WR_HI: st_q <= ST_WR_LO;
                ST_WR_LO: begin
                    sp_q   <= sp_q - TWO;
                    pc_q   <= (op_q == OP_CALL) ? tgt_q : pc_q + ONE;
                    done_q <= 1'b1;
                    st_q   <= ST_IDLE;
                end
                ST_RD_LO: begin
                    lo_q <= mem_rdata;
                    st_q <= ST_RD_HI;
                end
                ST_RD_HI: begin
                    sp_q <= sp_q + TWO;
                    if (op_q == OP_RET) begin
                        pc_q <= {mem_rdata, lo_q};
                    end else begin
                        pc_q     <= pc_q + ONE;
                        pop_q    <= {mem_rdata, lo_q};
                        pop_we_q <= 1'b1;
                    end
                    done_q <= 1'b1;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = sp_q;
        mem_wdata = '0;
        case (st_q)
            ST_WR_HI: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q - ONE;
                mem_wdata = data_q[AW-1:DW];
            end
            ST_WR_LO: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q - TWO;
                mem_wdata = data_q[DW-1:0];
            end
            ST_RD_LO: mem_re = 1'b1;
            ST_RD_HI: begin
                mem_re   = 1'b1;
                mem_addr = sp_q + ONE;
            end
            default: ;
        endcase
    end

    assign pc       = pc_q;
    assign sp       = sp_q;
    assign busy     = (st_q != ST_IDLE);
    assign done     = done_q;
    assign b_out    = b_q;
    assign b_we     = b_we_q;
    assign pop_data = pop_q;
    assign pop_we   = pop_we_q;

    a_r11_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    a_r11_mem_in_busy: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> busy);

    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, mem_re}));

    a_r9_writes_descend: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - ONE));

    a_r8_reads_ascend: assert property (@(posedge clk) disable iff (rst)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + ONE));

    a_r12_sp_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(sp) |-> (done && (sp == $past(sp) - TWO || sp == $past(sp) + TWO)));

    a_r4_loop_dec: assert property (@(posedge clk) disable iff (rst)
        b_we |-> (b_out == $past(b_in) - DW'(1) && done));

    a_r10_pop_with_done: assert property (@(posedge clk) disable iff (rst)
        pop_we |-> (done && $past(mem_re)));

endmodule

// File: tb/sim_pcsp_sequencer.sv
module sim_pcsp_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = '0;
    logic [2:0]  req_cond = '0;
    logic [15:0] req_imm = '0;
    logic [15:0] req_pair = '0;
    logic [7:0]  flags = '0;
    logic [7:0]  b_in = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] pc, sp, mem_addr, pop_data;
    logic        busy, done, mem_we, mem_re, b_we, pop_we;
    logic [7:0]  mem_wdata, b_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [7:0]  bmem [0:255];
    logic [15:0] w_addr [0:3];
    logic [7:0]  w_data [0:3];
    logic [15:0] r_addr [0:3];
    int          nw = 0;
    int          nr = 0;
    logic        busy1 = 1'b0;

    logic [15:0] pc_m, sp_m;

    always #2 clk = ~clk;

    pcsp_sequencer u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_cond(req_cond), .req_imm(req_imm), .req_pair(req_pair),
        .flags(flags), .b_in(b_in), .mem_rdata(mem_rdata),
        .pc(pc), .sp(sp), .busy(busy), .done(done), .mem_we(mem_we),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .b_out(b_out), .b_we(b_we), .pop_data(pop_data), .pop_we(pop_we)
    );

    assign mem_rdata = bmem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (nw < 4) begin
                    w_addr[nw] = mem_addr;
                    w_data[nw] = mem_wdata;
                end
                nw++;
                bmem[mem_addr[7:0]] <= mem_wdata;
            end
            if (mem_re) begin
                if (nr < 4) r_addr[nr] = mem_addr;
                nr++;
            end
        end
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [2:0] c,
                         input logic [15:0] imm, input logic [15:0] pair,
                         input logic [7:0] fl, input logic [7:0] bb,
                         output int lat);
        @(negedge clk);
        req_op = op; req_cond = c; req_imm = imm; req_pair = pair;
        flags = fl; b_in = bb; req_valid = 1'b1;
        nw = 0; nr = 0;
        @(negedge clk);
        req_valid = 1'b0;
        busy1 = busy;
        lat = 1;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic logic [15:0] sx(input logic [7:0] d);
        return {{8{d[7]}}, d};
    endfunction

    function automatic logic cond_true(input logic [2:0] c, input logic [7:0] fl);
        logic f;
        case (c[2:1])
            2'd0: f = fl[6];
            2'd1: f = fl[0];
            2'd2: f = fl[2];
            default: f = fl[7];
        endcase
        return c[0] ? f : !f;
    endfunction

    initial begin
        int lat;
        for (int i = 0; i < 256; i++) bmem[i] = 8'h00;

        repeat (3) @(negedge clk);
        chk("R1 pc", pc, 16'h0000);
        chk("R1 sp", sp, 16'h0000);
        chk("R1 strobes", {busy, done, mem_we, mem_re, b_we, pop_we}, 0);
        rst = 1'b0;
        pc_m = 16'h0000; sp_m = 16'h0000;

        // R5 absolute jump
        issue(4'd3, 3'd0, 16'h4000, 16'h0, 8'h00, 8'h0, lat);
        pc_m = 16'h4000;
        chk("R5 jp pc", pc, pc_m);
        chk("R5 jp latency", lat, 1);

        // R2 sweep of every displacement
        for (int d = 0; d < 256; d++) begin
            issue(4'd0, 3'd5, {8'h00, 8'(d)}, 16'h0, 8'hFF, 8'h0, lat);
            pc_m = pc_m + 16'd2 + sx(8'(d));
            chk("R2 jr pc", pc, pc_m);
            chk("R2 jr latency", lat, 1);
            chk("R2 jr sp", sp, sp_m);
        end

        // R3 short condition: bit 2 and unrelated flags ignored
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 4; f++) begin
                logic [7:0] fl;
                logic       tk;
                fl = {~f[1], f[1], 3'b000, ~f[1], 1'b0, f[0]};
                case (c % 4)
                    0: tk = !f[1];
                    1: tk = f[1];
                    2: tk = !f[0];
                    default: tk = f[0];
                endcase
                issue(4'd1, 3'(c), 16'h0020, 16'h0, fl, 8'h0, lat);
                pc_m = tk ? pc_m + 16'd2 + 16'h0020 : pc_m + 16'd2;
                chk("R3 jr-if pc", pc, pc_m);
                chk("R3 jr-if latency", lat, 1);
            end
        end

        // R5 full condition set over S, Z, P/V, C
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic [7:0]  fl;
                logic [15:0] tg;
                fl = {f[3], f[2], 3'b101, f[1], 1'b1, f[0]};
                tg = 16'h1000 + 16'(c * 16 + f);
                issue(4'd4, 3'(c), tg, 16'h0, fl, 8'h0, lat);
                pc_m = cond_true(3'(c), fl) ? tg : pc_m + 16'd3;
                chk("R5 jp-if pc", pc, pc_m);
            end
        end

        // R4 loop counter sweep, displacement -16
        for (int b = 0; b < 256; b++) begin
            logic [7:0] nb;
            nb = 8'(b) - 8'd1;
            issue(4'd2, 3'd0, 16'h00F0, 16'h0, 8'h00, 8'(b), lat);
            pc_m = (nb != 0) ? pc_m + 16'd2 - 16'd16 : pc_m + 16'd2;
            chk("R4 loop pc", pc, pc_m);
            chk("R4 loop b_out", {b_we, b_out}, {1'b1, nb});
        end

        // R6 call from sp 0 (R12 wrap downwards)
        issue(4'd3, 3'd0, 16'h2345, 16'h0, 8'h00, 8'h0, lat);
        pc_m = 16'h2345;
        issue(4'd5, 3'd0, 16'h3000, 16'h0, 8'h00, 8'h0, lat);
        chk("R11 call latency", lat, 3);
        chk("R11 call busy", busy1, 1'b1);
        chk("R6 write count", nw, 2);
        chk("R6 hi write", {w_addr[0], w_data[0]}, {16'hFFFF, 8'h23});
        chk("R6 lo write", {w_addr[1], w_data[1]}, {16'hFFFE, 8'h48});
        chk("R6 call pc", pc, 16'h3000);
        chk("R12 call sp", sp, 16'hFFFE);
        pc_m = 16'h3000; sp_m = 16'hFFFE;

        // R9 push
        issue(4'd9, 3'd0, 16'h0, 16'hBEEF, 8'h00, 8'h0, lat);
        chk("R9 push latency", lat, 3);
        chk("R9 hi write", {w_addr[0], w_data[0]}, {16'hFFFD, 8'hBE});
        chk("R9 lo write", {w_addr[1], w_data[1]}, {16'hFFFC, 8'hEF});
        pc_m = pc_m + 16'd1; sp_m = 16'hFFFC;
        chk("R9 push pc/sp", {pc, sp}, {pc_m, sp_m});

        // R10 pop
        issue(4'd10, 3'd0, 16'h0, 16'h0, 8'h00, 8'h0, lat);
        chk("R10 pop latency", lat, 3);
        chk("R10 read order", {r_addr[0], r_addr[1]}, {16'hFFFC, 16'hFFFD});
        chk("R10 pop data", {pop_we, pop_data}, {1'b1, 16'hBEEF});
        pc_m = pc_m + 16'd1; sp_m = 16'hFFFE;
        chk("R10 pop pc/sp", {pc, sp}, {pc_m, sp_m});

        // R7 untaken conditional call and return
        issue(4'd6, 3'd1, 16'h5555, 16'h0, 8'h00, 8'h0, lat);
        pc_m = pc_m + 16'd3;
        chk("R7 call-if skip", {pc, sp}, {pc_m, sp_m});
        chk("R7 call-if no access", nw + nr, 0);
        chk("R7 call-if latency", lat, 1);
        issue(4'd8, 3'd7, 16'h0, 16'h0, 8'h00, 8'h0, lat);
        pc_m = pc_m + 16'd1;
        chk("R7 ret-if skip", {pc, sp}, {pc_m, sp_m});
        chk("R7 ret-if no access", nw + nr, 0);

        // R8 return (R12 wrap upwards)
        issue(4'd7, 3'd0, 16'h0, 16'h0, 8'h00, 8'h0, lat);
        chk("R8 ret latency", lat, 3);
        chk("R8 read order", {r_addr[0], r_addr[1]}, {16'hFFFE, 16'hFFFF});
        pc_m = 16'h2348; sp_m = 16'h0000;
        chk("R8 ret pc", pc, pc_m);
        chk("R12 ret sp", sp, sp_m);

        // R6 / R8 taken conditional call and return on sign set
        issue(4'd6, 3'd7, 16'h6000, 16'h0, 8'h80, 8'h0, lat);
        chk("R6 call-if pc/sp", {pc, sp}, {16'h6000, 16'hFFFE});
        chk("R6 call-if lo", {w_addr[1], w_data[1]}, {16'hFFFE, 8'h4B});
        issue(4'd8, 3'd7, 16'h0, 16'h0, 8'h80, 8'h0, lat);
        pc_m = 16'h234B; sp_m = 16'h0000;
        chk("R8 ret-if pc/sp", {pc, sp}, {pc_m, sp_m});

        // R11 request during busy is ignored
        @(negedge clk);
        req_op = 4'd9; req_pair = 16'h1111; req_valid = 1'b1;
        @(negedge clk);
        req_op = 4'd3; req_imm = 16'h7777;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11 done after push", done, 1'b1);
        pc_m = pc_m + 16'd1; sp_m = 16'hFFFE;
        chk("R11 busy request ignored", {pc, sp}, {pc_m, sp_m});
        @(negedge clk);
        chk("R11 idle after done", {busy, done, pc}, {1'b0, 1'b0, pc_m});

        // R11 unused op code
        issue(4'd12, 3'd0, 16'h9999, 16'h0, 8'hFF, 8'h0, lat);
        chk("R11 unused op no done", lat, 8);
        chk("R11 unused op state", {pc, sp}, {pc_m, sp_m});

        report();
        $finish;
    end

endmodule